// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Carry

This block moves an operand by exactly one bit position, or inverts it, and produces the condition flags that such an operation leaves behind. The operand may be a byte, a word or a long (8, 16 or 32 bits with the default parameters). The caller selects the width and one of nine operations. Four are plain shifts: logical left and right, arithmetic left and right. There is bitwise inversion. There are two plain rotates, and two rotates that pass through the carry flag. The caller also supplies the incoming carry flag.

The outputs are the result, zero-extended to the full datapath width, and four flags. N is the sign bit of the result at the selected width. Z is set when the result is zero at that width. V is always cleared. C depends on the operation: it holds the bit shifted or rotated out, or it passes straight through. One lane per width computes its result in parallel, and the selected lane is muxed out. An optional output register, present by default, gives a one-cycle latency with a synchronous active-low clear.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (invert) gives the bitwise complement of the operand at the selected width, and C out equals C in.
- R2: Operation codes 1 (logical left) and 3 (arithmetic left) shift the operand left by one and shift a 0 into bit 0. C out takes the operand's top bit at the selected width.
- R3: Operation code 2 (logical right) shifts right by one, shifts a 0 into the top bit, and sets C out to operand bit 0.
- R4: Operation code 4 (arithmetic right) shifts right by one, keeps the top bit of the selected width unchanged, and sets C out to operand bit 0.
- R5: Operation code 5 (rotate left) copies the old top bit into both bit 0 and C out. Operation code 6 (rotate right) copies old bit 0 into both the top bit and C out.
- R6: Operation code 7 (rotate left through carry) puts C in into bit 0 and the old top bit into C out. Operation code 8 (rotate right through carry) puts C in into the top bit and old bit 0 into C out.
- R7: For every operation, V out is 0. N out is result bit 7, 15 or 31 for size codes 0 (byte), 1 (word) or 2 (long). Z out is 1 exactly when the result at the selected width is zero.
- R8: Result bits above the selected width are 0. Operand bits above the selected width have no effect on any output.
- R9: Operation codes 9 to 15 return the operand unchanged at the selected width, with C out equal to C in. N, Z and V follow R7.
- R10: Size code 3 behaves exactly like size code 2 (long).
- R11: With the output register enabled (the default), all outputs change only at a rising clock edge, one cycle after the inputs. A low rst_n sampled at an edge clears the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low clear of the output register |
| op_i | input | 4 | Operation code (0 to 8 defined, 9 to 15 pass-through) |
| size_i | input | 2 | Operand width: 0 byte, 1 word, 2 or 3 long |
| operand_i | input | LONG_W (32) | Operand; only the selected low bits are used |
| c_i | input | 1 | Incoming carry flag |
| result_o | output | LONG_W (32) | Result, zero above the selected width |
| n_o | output | 1 | Sign of the result at the selected width |
| z_o | output | 1 | Result at the selected width is zero |
| v_o | output | 1 | Overflow flag, always cleared |
| c_o | output | 1 | Outgoing carry flag |

## Verification
The bench aims each operation at the top bit of every width. A design that took the carry or sign from bit 31 regardless of size would report the wrong C or N for byte and word operands. Operands with garbage above the selected width expose a lane that leaks high bits into the result or Z. The arithmetic left shift of 0x4000 checks that V stays low even where a signed overflow occurs. The through-carry rotates are run with both carry values, which separates them from the plain rotates. Directed steps check that the output holds until the clock edge and that the reset clears it.

// File: rtl/shrot_pkg.sv
// Package: shared encodings for the single-step shift and rotate unit.
// Assumes the long width is a multiple of four so byte and word derive from it.
package shrot_pkg;

    // Operation codes presented on op_i; values outside this list pass through.
    typedef enum logic [3:0] {
        OP_INV = 4'd0,
        OP_LSL = 4'd1,
        OP_LSR = 4'd2,
        OP_ASL = 4'd3,
        OP_ASR = 4'd4,
        OP_ROL = 4'd5,
        OP_ROR = 4'd6,
        OP_RCL = 4'd7,
        OP_RCR = 4'd8
    } sr_op_e;

    // Width select codes presented on size_i.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG2 = 2'd3
    } sr_size_e;

    // Number of operand widths handled by parallel lanes.
    localparam int NUM_LANES = 3;

    // Map a size code to a lane index; code 3 aliases the long lane.
    function automatic logic [1:0] lane_index(input logic [1:0] size);
        logic [1:0] idx;
        case (size)
            SZ_BYTE: idx = 2'd0;
            SZ_WORD: idx = 2'd1;
            default: idx = 2'd2;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/shrot_lane.sv
// Module: one single-step shift/rotate lane of fixed width W.
// Computes the shifted result and the outgoing carry for all operation codes.
// Assumes W >= 2. Purely combinational.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] operand_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);

    localparam int MSB = W - 1;

    // Select the one-position transform and the carry it produces.
    always_comb begin
        res_o = operand_i;
        c_o   = c_i;
        case (op_i)
            OP_INV: begin
                res_o = ~operand_i;
            end
            OP_LSL, OP_ASL: begin
                res_o = {operand_i[MSB-1:0], 1'b0};
                c_o   = operand_i[MSB];
            end
            OP_LSR: begin
                res_o = {1'b0, operand_i[MSB:1]};
                c_o   = operand_i[0];
            end
            OP_ASR: begin
                res_o = {operand_i[MSB], operand_i[MSB:1]};
                c_o   = operand_i[0];
            end
            OP_ROL: begin
                res_o = {operand_i[MSB-1:0], operand_i[MSB]};
                c_o   = operand_i[MSB];
            end
            OP_ROR: begin
                res_o = {operand_i[0], operand_i[MSB:1]};
                c_o   = operand_i[0];
            end
            OP_RCL: begin
                res_o = {operand_i[MSB-1:0], c_i};
                c_o   = operand_i[MSB];
            end
            OP_RCR: begin
                res_o = {c_i, operand_i[MSB:1]};
                c_o   = operand_i[0];
            end
            default: begin
                res_o = operand_i;
                c_o   = c_i;
            end
        endcase
    end

    // Guard the carry and edge-bit behaviour of each operation class.
    always_comb begin
        if (op_i == OP_LSL || op_i == OP_ASL) begin
            a_r2_left_carry: assert (c_o == operand_i[MSB] && res_o[0] == 1'b0)
                else $error("left shift carry/fill wrong");
        end
        if (op_i == OP_ASR) begin
            a_r4_sign_kept: assert (res_o[MSB] == operand_i[MSB] && c_o == operand_i[0])
                else $error("arithmetic right lost sign");
        end
        if (op_i == OP_RCL) begin
            a_r6_rcl_carry: assert (res_o[0] == c_i && c_o == operand_i[MSB])
                else $error("rotate left through carry wrong");
        end
        if (op_i == OP_RCR) begin
            a_r6_rcr_carry: assert (res_o[MSB] == c_i && c_o == operand_i[0])
                else $error("rotate right through carry wrong");
        end
        if (op_i == OP_INV) begin
            a_r1_inv_carry: assert (c_o == c_i && (res_o ^ operand_i) == {W{1'b1}})
                else $error("invert wrong");
        end
    end

endmodule

// File: rtl/shrot_flags.sv
// Module: sign and zero flag generation for a zero-extended result.
// Assumes bits above the selected width are already zero.
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int LONG_W = 32
) (
    input  logic [LONG_W-1:0] res_i,
    input  logic [1:0]        size_i,
    output logic              n_o,
    output logic              z_o
);

    localparam int BYTE_W = LONG_W / 4;

    logic [NUM_LANES-1:0] sign_bits;

    // Collect the sign bit of each width.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_sign
        assign sign_bits[g] = res_i[(BYTE_W << g) - 1];
    end

    // Pick the sign of the selected width and detect an all-zero result.
    always_comb begin
        case (lane_index(size_i))
            2'd0:    n_o = sign_bits[0];
            2'd1:    n_o = sign_bits[1];
            default: n_o = sign_bits[2];
        endcase
        z_o = ~|res_i;
    end

endmodule

// File: rtl/shrot_ostage.sv
// Module: optional output stage. With REGISTERED set it is a register with a
// synchronous active-low clear to zero; otherwise a straight wire.
module shrot_ostage #(
    parameter int DW         = 36,
    parameter bit REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);

    if (REGISTERED) begin : g_reg
        logic [DW-1:0] q_r;
        // Capture the next output word, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d_i;
        end
        assign q_o = q_r;
    end else begin : g_wire
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign q_o = d_i;
    end

endmodule

// File: rtl/shrot_unit.sv
// Module: top of the single-step shift and rotate unit.
// Runs one lane per width in parallel, selects by size, builds N/Z/V/C and
// passes everything through the optional output stage.
// Assumes LONG_W is a multiple of four and at least 8.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int LONG_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [LONG_W-1:0] operand_i,
    input  logic              c_i,
    output logic [LONG_W-1:0] result_o,
    output logic              n_o,
    output logic              z_o,
    output logic              v_o,
    output logic              c_o
);

    localparam int BYTE_W = LONG_W / 4;
    localparam int PACK_W = LONG_W + 4;

    logic [LONG_W-1:0]    lane_ext [NUM_LANES];
    logic [NUM_LANES-1:0] lane_c;
    logic [LONG_W-1:0]    sel_res;
    logic                 sel_c;
    logic                 sel_n;
    logic                 sel_z;
    logic [PACK_W-1:0]    stage_d;
    logic [PACK_W-1:0]    stage_q;

    // One lane per operand width, each fed the low bits it owns.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = BYTE_W << g;
        logic [LW-1:0] lane_res;
        shrot_lane #(.W(LW)) u_lane (
            .op_i      (op_i),
            .operand_i (operand_i[LW-1:0]),
            .c_i       (c_i),
            .res_o     (lane_res),
            .c_o       (lane_c[g])
        );
        assign lane_ext[g] = LONG_W'(lane_res);
    end

    // Select the lane that matches the requested width.
    always_comb begin
        case (lane_index(size_i))
            2'd0: begin
                sel_res = lane_ext[0];
                sel_c   = lane_c[0];
            end
            2'd1: begin
                sel_res = lane_ext[1];
                sel_c   = lane_c[1];
            end
            default: begin
                sel_res = lane_ext[2];
                sel_c   = lane_c[2];
            end
        endcase
    end

    shrot_flags #(.LONG_W(LONG_W)) u_flags (
        .res_i  (sel_res),
        .size_i (size_i),
        .n_o    (sel_n),
        .z_o    (sel_z)
    );

    // Pack result and flags; V is cleared for every operation.
    assign stage_d = {sel_res, sel_n, sel_z, 1'b0, sel_c};

    shrot_ostage #(.DW(PACK_W), .REGISTERED(OUT_REG)) u_ostage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stage_d),
        .q_o   (stage_q)
    );

    assign {result_o, n_o, z_o, v_o, c_o} = stage_q;

    // Zero flag at the output agrees with the result at the output.
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        z_o |-> (result_o == '0))
        else $error("Z set with nonzero result");

    // A byte-sized selection never leaks bits above the byte.
    a_r8_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_index(size_i) == 2'd0) |-> (lane_ext[0][LONG_W-1:BYTE_W] == '0 && sel_res == lane_ext[0]))
        else $error("byte lane upper bits nonzero");

endmodule

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;

    localparam int NV = 21;
    // {op, size, cin, operand, expected result, expected {N,Z,V,C}}
    localparam logic [74:0] VEC [NV] = '{
        {4'd0, 2'd0, 1'b1, 32'h000000F0, 32'h0000000F, 4'b0001}, // R1 byte invert, C kept
        {4'd0, 2'd1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 4'b0100}, // R1 R8 word invert to zero
        {4'd1, 2'd0, 1'b0, 32'h00000081, 32'h00000002, 4'b0001}, // R2 byte lsl
        {4'd3, 2'd1, 1'b0, 32'h00004000, 32'h00008000, 4'b1000}, // R2 R7 asl overflow keeps V low
        {4'd1, 2'd2, 1'b1, 32'h80000000, 32'h00000000, 4'b0101}, // R2 long lsl to zero
        {4'd2, 2'd0, 1'b0, 32'h00000081, 32'h00000040, 4'b0001}, // R3 byte lsr
        {4'd2, 2'd2, 1'b0, 32'h80000001, 32'h40000000, 4'b0001}, // R3 long lsr
        {4'd4, 2'd0, 1'b0, 32'h00000081, 32'h000000C0, 4'b1001}, // R4 byte asr negative
        {4'd4, 2'd1, 1'b0, 32'h00007FFE, 32'h00003FFF, 4'b0000}, // R4 word asr positive
        {4'd4, 2'd2, 1'b0, 32'h80000000, 32'hC0000000, 4'b1000}, // R4 long asr
        {4'd5, 2'd0, 1'b0, 32'h00000081, 32'h00000003, 4'b0001}, // R5 byte rotate left
        {4'd6, 2'd1, 1'b0, 32'h00000001, 32'h00008000, 4'b1001}, // R5 word rotate right
        {4'd6, 2'd2, 1'b1, 32'h00000002, 32'h00000001, 4'b0000}, // R5 long rotate right, cin unused
        {4'd7, 2'd0, 1'b0, 32'h00000080, 32'h00000000, 4'b0101}, // R6 byte rcl
        {4'd7, 2'd1, 1'b1, 32'h00000001, 32'h00000003, 4'b0000}, // R6 word rcl carry in
        {4'd8, 2'd2, 1'b1, 32'h00000001, 32'h80000000, 4'b1001}, // R6 long rcr
        {4'd8, 2'd0, 1'b0, 32'h00000002, 32'h00000001, 4'b0000}, // R6 byte rcr
        {4'd9, 2'd0, 1'b1, 32'h123456A5, 32'h000000A5, 4'b1001}, // R9 pass-through byte
        {4'd15,2'd1, 1'b0, 32'h00000000, 32'h00000000, 4'b0100}, // R9 pass-through word zero
        {4'd1, 2'd3, 1'b0, 32'h40000000, 32'h80000000, 4'b1000}, // R10 size 3 as long
        {4'd1, 2'd0, 1'b0, 32'hFFFFFF40, 32'h00000080, 4'b1000}  // R8 upper operand bits ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] operand_i = '0;
    logic        c_i = 1'b0;
    logic [31:0] result_o;
    logic        n_o, z_o, v_o, c_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .operand_i(operand_i), .c_i(c_i), .result_o(result_o),
        .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
    );

    task automatic check(input logic [31:0] exp_res, input logic [3:0] exp_f, input string tag);
        checks++;
        if (result_o !== exp_res || {n_o, z_o, v_o, c_o} !== exp_f) begin
            errors++;
            $display("FAIL %s: result %h flags %b expected result %h flags %b",
                     tag, result_o, {n_o, z_o, v_o, c_o}, exp_res, exp_f);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [1:0] sz, input logic ci, input logic [31:0] d);
        @(negedge clk);
        op_i = op; size_i = sz; c_i = ci; operand_i = d;
        @(negedge clk);
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check(32'h0, 4'b0000, "R11 reset state");
        rst_n = 1'b1;

        // Table walk covering R1..R10
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][74:71], VEC[i][70:69], VEC[i][68], VEC[i][67:36]);
            check(VEC[i][35:4], VEC[i][3:0], $sformatf("R1-table vector %0d", i));
        end

        // R11 output holds until the clock edge
        apply(4'd0, 2'd0, 1'b0, 32'h000000FF);
        check(32'h0, 4'b0100, "R1 invert of 0xFF byte");
        @(negedge clk);
        op_i = 4'd9; size_i = 2'd2; operand_i = 32'h5A5A5A5A; c_i = 1'b1;
        #1;
        check(32'h0, 4'b0100, "R11 holds before edge");
        @(negedge clk);
        check(32'h5A5A5A5A, 4'b0001, "R11 updates after one edge");

        // R11 synchronous reset clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(32'h5A5A5A5A, 4'b0001, "R11 reset waits for edge");
        @(negedge clk);
        check(32'h0, 4'b0000, "R11 reset clears outputs");
        rst_n = 1'b1;

        // R7 sign position per width with same operand
        apply(4'd9, 2'd1, 1'b0, 32'h80008000);
        check(32'h00008000, 4'b1000, "R7 word sign at bit 15");
        apply(4'd9, 2'd0, 1'b0, 32'h80008000);
        check(32'h00000000, 4'b0100, "R7 R8 byte zero despite high bits");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule